// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Controller

This block watches the CPU bus and raises a break request to the core when a programmed condition is met. It has two comparison channels, A and B. Each channel compares the bus address, with a per-bit don't-care mask, against its own address. It also checks the kind of bus cycle against a selected kind. On a data channel it can also compare the data word. A fetch channel breaks either before the matched instruction runs (pre-execution) or after it completes (post-execution). A data channel always breaks after the access, when the instruction completes.

The two channels can be chained into a sequential condition. A channel A hit arms the sequence. A channel B hit in a strictly later bus cycle completes it, and the break then follows channel B's timing. Each channel has a sticky condition flag that is cleared by a strobe.

Sideband inputs from the core describe the instruction that completes and the instruction that follows it. They let the block keep the flag but drop the break when the following instruction traps, sleeps, faults or takes a nonmaskable interrupt.

Top module: `dbgbrk_top`

## Requirements
- R1: A channel hits only when it is enabled, `bus_valid` is high, every address bit with a mask bit of 0 equals the channel address, and the cycle kind agrees. `bus_kind` encodings: 0 fetch, 1 read, 2 write, 3 none. `ch_sel` encodings: 0 fetch, 1 read, 2 write, 3 read or write.
- R2: On a data channel (`ch_sel` not 0) with `ch_data_en` set, the hit also needs `bus_data` equal to the channel data. A data hit arms a break that is issued on the next `insn_done`, whatever `ch_post` says.
- R3: A hit of a pre-execution fetch channel (`ch_post` = 0) drives `brk_req` high in the same cycle as the bus cycle.
- R4: A hit of a post-execution fetch channel (`ch_post` = 1) issues no request in its own cycle. It issues a one-cycle `brk_req` in the first later cycle with `insn_done` high, and that consumes the pending break.
- R5: When a pre-execution hit and a post-execution hit occur in the same cycle, only the pre-execution request is issued, no post-execution request follows, and both condition flags are set.
- R6: `cond_flag[0]` (A) and `cond_flag[1]` (B) are set by their channel's condition and stay set until a `flag_clr` strobe on that bit. A set in the same cycle as a clear wins.
- R7: With `seq_en` high, a channel A hit sets `seq_armed`, sets flag A and issues no break. A later channel B hit while armed sets flag B, clears `seq_armed` and issues B's break.
- R8: With `seq_en` high and the sequence not armed, hits of A and B in the same bus cycle do not complete the sequence: flag B stays clear and no break is issued.
- R9: Sequential order is the order of bus cycles, whatever their kind. An A data write followed by a B fetch completes the sequence. A B fetch before any A hit does not.
- R10: A pending post-execution fetch break is dropped, with the flag kept, when `insn_done` comes with `done_trap` (the completing instruction is a trap).
- R11: A pending data break is dropped, with the flag kept, when `insn_done` comes with `nx_exc` (the next instruction, including a delay slot, raises an exception) or with `nx_sleep`.
- R12: A pending post-execution fetch break is dropped, with the flag kept, when `insn_done` comes with `nx_nmi`.
- R13: `seq_clr` clears `seq_armed` at the next edge, overriding a channel A hit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is present |
| bus_kind | input | 2 | Cycle kind: 0 fetch, 1 read, 2 write, 3 none |
| bus_addr | input | AW | Bus address |
| bus_data | input | DW | Bus data |
| ch_en | input | 2 | Channel enable, bit 0 = A, bit 1 = B |
| ch_sel | input | 2x2 | Cycle kind each channel selects |
| ch_post | input | 2 | Fetch timing: 1 post-execution, 0 pre-execution |
| ch_addr | input | 2xAW | Channel compare address |
| ch_mask | input | 2xAW | Address don't-care bits (1 = ignore) |
| ch_data | input | 2xDW | Channel compare data |
| ch_data_en | input | 2 | Include data in the compare |
| seq_en | input | 1 | Chain A then B |
| seq_clr | input | 1 | Drop an armed sequence |
| flag_clr | input | 2 | Clear strobe per condition flag |
| insn_done | input | 1 | The matched instruction has completed |
| done_trap | input | 1 | The completing instruction is a trap |
| nx_exc | input | 1 | The next instruction raises an exception |
| nx_sleep | input | 1 | The next instruction is a sleep |
| nx_nmi | input | 1 | A nonmaskable interrupt is taken at the next instruction |
| brk_req | output | 1 | Break request pulse to the core |
| cond_flag | output | 2 | Sticky condition flags, bit 0 = A, bit 1 = B |
| seq_armed | output | 1 | Sequential condition waiting for channel B |

## Verification
The bench sets a pre-execution channel and a post-execution channel on the same address. A design without cross-channel priority would then issue a second, late request on `insn_done`. It hits A and B in one bus cycle in sequential mode, where a design that compared against the current cycle instead of a registered armed state would complete the chain early. It also runs a B fetch before an A write, to catch ordering tied to cycle kind instead of arrival. Each suppression input is applied to the class of break it governs, so a design that missed one would pulse `brk_req` after a trap, sleep, exception or interrupt. A design that forgot to clear the pending state would pulse again on the next completion.

// File: rtl/dbgbrk_pkg.sv
package dbgbrk_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    BK_FETCH = 2'd0,
    BK_READ  = 2'd1,
    BK_WRITE = 2'd2,
    BK_NONE  = 2'd3
  } bus_kind_e;

  typedef enum logic [1:0] {
    SEL_FETCH = 2'd0,
    SEL_READ  = 2'd1,
    SEL_WRITE = 2'd2,
    SEL_RDWR  = 2'd3
  } chan_sel_e;
endpackage

// File: rtl/dbgbrk_chan.sv
module dbgbrk_chan
  import dbgbrk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          bus_valid,
  input  logic [1:0]    bus_kind,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          en,
  input  logic [1:0]    sel,
  input  logic          post,
  input  logic [AW-1:0] cmp_addr,
  input  logic [AW-1:0] cmp_mask,
  input  logic [DW-1:0] cmp_data,
  input  logic          data_en,
  output logic          hit,
  output logic          fetch_pre,
  output logic          fetch_post,
  output logic          data_cls
);
  bus_kind_e kind;
  chan_sel_e csel;
  logic      kind_ok;
  logic      addr_ok;
  logic      data_ok;

  assign kind = bus_kind_e'(bus_kind);
  assign csel = chan_sel_e'(sel);

  always_comb begin
    unique case (csel)
      SEL_FETCH: kind_ok = (kind == BK_FETCH);
      SEL_READ:  kind_ok = (kind == BK_READ);
      SEL_WRITE: kind_ok = (kind == BK_WRITE);
      default:   kind_ok = (kind == BK_READ) || (kind == BK_WRITE);
    endcase
  end

  assign addr_ok    = ((bus_addr ^ cmp_addr) & ~cmp_mask) == '0;
  assign data_cls   = (csel != SEL_FETCH);
  assign data_ok    = !(data_cls && data_en) || (bus_data == cmp_data);
  assign hit        = en && bus_valid && kind_ok && addr_ok && data_ok;
  assign fetch_pre  = (csel == SEL_FETCH) && !post;
  assign fetch_post = (csel == SEL_FETCH) && post;
endmodule

// File: rtl/dbgbrk_seq.sv
module dbgbrk_seq
  import dbgbrk_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           seq_en,
  input  logic           seq_clr,
  input  logic [NCH-1:0] hit,
  input  logic [NCH-1:0] flag_clr,
  output logic [NCH-1:0] ev,
  output logic [NCH-1:0] flag_q,
  output logic           armed_q
);
  logic [NCH-1:0] flag_d;
  logic [NCH-1:0] flag_set;
  logic           armed_d;
  logic           flag_upd;
  logic           armed_upd;

  // Effective break events: in chained mode A only arms, B needs prior arming
  always_comb begin
    ev[0] = hit[0] && !seq_en;
    ev[1] = hit[1] && (!seq_en || armed_q);
  end

  always_comb begin
    flag_set  = {ev[1], hit[0]};
    flag_d    = flag_set | (flag_q & ~flag_clr);
    flag_upd  = |flag_set || |flag_clr;
    if (seq_clr || !seq_en) begin
      armed_d = 1'b0;
    end else if (hit[0]) begin
      armed_d = 1'b1;
    end else if (ev[1]) begin
      armed_d = 1'b0;
    end else begin
      armed_d = armed_q;
    end
    armed_upd = (armed_d != armed_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (flag_upd) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (armed_upd) begin
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/dbgbrk_gate.sv
module dbgbrk_gate
  import dbgbrk_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev,
  input  logic [NCH-1:0] fetch_pre,
  input  logic [NCH-1:0] fetch_post,
  input  logic [NCH-1:0] data_cls,
  input  logic           insn_done,
  input  logic           done_trap,
  input  logic           nx_exc,
  input  logic           nx_sleep,
  input  logic           nx_nmi,
  output logic           pre_fire,
  output logic           pend_fetch_q,
  output logic           pend_data_q,
  output logic           brk_req
);
  logic arm_fetch;
  logic arm_data;
  logic post_fire;
  logic pend_fetch_d;
  logic pend_data_d;
  logic pend_upd;

  always_comb begin
    pre_fire  = |(ev & fetch_pre);
    // pre-execution wins: post arms in the same cycle are discarded
    arm_fetch = |(ev & fetch_post) && !pre_fire;
    arm_data  = |(ev & data_cls) && !pre_fire;
    post_fire = insn_done &&
                ((pend_fetch_q && !done_trap && !nx_nmi) ||
                 (pend_data_q  && !nx_exc    && !nx_sleep));
    pend_fetch_d = (pend_fetch_q && !insn_done) || arm_fetch;
    pend_data_d  = (pend_data_q  && !insn_done) || arm_data;
    pend_upd     = insn_done || arm_fetch || arm_data;
    brk_req      = pre_fire || post_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_fetch_q <= 1'b0;
      pend_data_q  <= 1'b0;
    end else if (pend_upd) begin
      pend_fetch_q <= pend_fetch_d;
      pend_data_q  <= pend_data_d;
    end
  end
endmodule

// File: rtl/dbgbrk_top.sv
module dbgbrk_top
  import dbgbrk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  input  logic [1:0]             bus_kind,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW-1:0]          bus_data,
  input  logic [1:0]             ch_en,
  input  logic [1:0][1:0]        ch_sel,
  input  logic [1:0]             ch_post,
  input  logic [1:0][AW-1:0]     ch_addr,
  input  logic [1:0][AW-1:0]     ch_mask,
  input  logic [1:0][DW-1:0]     ch_data,
  input  logic [1:0]             ch_data_en,
  input  logic                   seq_en,
  input  logic                   seq_clr,
  input  logic [1:0]             flag_clr,
  input  logic                   insn_done,
  input  logic                   done_trap,
  input  logic                   nx_exc,
  input  logic                   nx_sleep,
  input  logic                   nx_nmi,
  output logic                   brk_req,
  output logic [1:0]             cond_flag,
  output logic                   seq_armed
);
  logic [1:0]     rst_sync;
  logic           rst_int_n;
  logic [NCH-1:0] hit;
  logic [NCH-1:0] fetch_pre;
  logic [NCH-1:0] fetch_post;
  logic [NCH-1:0] data_cls;
  logic [NCH-1:0] ev;
  logic           pre_fire;
  logic           pend_fetch;
  logic           pend_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dbgbrk_chan #(.AW(AW), .DW(DW)) u_chan (
      .bus_valid (bus_valid),
      .bus_kind  (bus_kind),
      .bus_addr  (bus_addr),
      .bus_data  (bus_data),
      .en        (ch_en[c]),
      .sel       (ch_sel[c]),
      .post      (ch_post[c]),
      .cmp_addr  (ch_addr[c]),
      .cmp_mask  (ch_mask[c]),
      .cmp_data  (ch_data[c]),
      .data_en   (ch_data_en[c]),
      .hit       (hit[c]),
      .fetch_pre (fetch_pre[c]),
      .fetch_post(fetch_post[c]),
      .data_cls  (data_cls[c])
    );
  end

  dbgbrk_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .seq_en  (seq_en),
    .seq_clr (seq_clr),
    .hit     (hit),
    .flag_clr(flag_clr),
    .ev      (ev),
    .flag_q  (cond_flag),
    .armed_q (seq_armed)
  );

  dbgbrk_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ev          (ev),
    .fetch_pre   (fetch_pre),
    .fetch_post  (fetch_post),
    .data_cls    (data_cls),
    .insn_done   (insn_done),
    .done_trap   (done_trap),
    .nx_exc      (nx_exc),
    .nx_sleep    (nx_sleep),
    .nx_nmi      (nx_nmi),
    .pre_fire    (pre_fire),
    .pend_fetch_q(pend_fetch),
    .pend_data_q (pend_data),
    .brk_req     (brk_req)
  );
endmodule

// File: rtl/dbgbrk_chk.sv
module dbgbrk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] hit,
  input logic       pre_fire,
  input logic       pend_fetch,
  input logic       pend_data,
  input logic       brk_req,
  input logic [1:0] cond_flag,
  input logic       seq_armed,
  input logic       seq_en,
  input logic       seq_clr,
  input logic [1:0] flag_clr,
  input logic       insn_done,
  input logic       done_trap,
  input logic       nx_exc,
  input logic       nx_sleep,
  input logic       nx_nmi
);
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_flag[0] && !flag_clr[0]) |=> cond_flag[0]);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[0] && !hit[0]) |=> !cond_flag[0]);

  // R4
  post_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !pre_fire) |-> insn_done);

  // R10 R12
  fetch_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && (done_trap || nx_nmi) && !pend_data && !pre_fire) |-> !brk_req);

  // R11
  data_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && (nx_exc || nx_sleep) && !pend_fetch && !pre_fire) |-> !brk_req);

  // R8
  seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_en && !seq_armed) |=> !$rose(cond_flag[1]));

  // R13
  seq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_clr |=> !seq_armed);
endmodule

bind dbgbrk_top dbgbrk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hit       (hit),
  .pre_fire  (pre_fire),
  .pend_fetch(pend_fetch),
  .pend_data (pend_data),
  .brk_req   (brk_req),
  .cond_flag (cond_flag),
  .seq_armed (seq_armed),
  .seq_en    (seq_en),
  .seq_clr   (seq_clr),
  .flag_clr  (flag_clr),
  .insn_done (insn_done),
  .done_trap (done_trap),
  .nx_exc    (nx_exc),
  .nx_sleep  (nx_sleep),
  .nx_nmi    (nx_nmi)
);

// File: tb/dbgbrk_top_test.sv
module dbgbrk_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  // side vector: {insn_done, done_trap, nx_exc, nx_sleep, nx_nmi}
  localparam logic [4:0] S_NONE  = 5'b00000;
  localparam logic [4:0] S_DONE  = 5'b10000;
  localparam logic [4:0] S_TRAP  = 5'b11000;
  localparam logic [4:0] S_EXC   = 5'b10100;
  localparam logic [4:0] S_SLEEP = 5'b10010;
  localparam logic [4:0] S_NMI   = 5'b10001;

  logic                 clk;
  logic                 rst_n;
  logic                 bus_valid;
  logic [1:0]           bus_kind;
  logic [AW-1:0]        bus_addr;
  logic [DW-1:0]        bus_data;
  logic [1:0]           ch_en;
  logic [1:0][1:0]      ch_sel;
  logic [1:0]           ch_post;
  logic [1:0][AW-1:0]   ch_addr;
  logic [1:0][AW-1:0]   ch_mask;
  logic [1:0][DW-1:0]   ch_data;
  logic [1:0]           ch_data_en;
  logic                 seq_en;
  logic                 seq_clr;
  logic [1:0]           flag_clr;
  logic                 insn_done;
  logic                 done_trap;
  logic                 nx_exc;
  logic                 nx_sleep;
  logic                 nx_nmi;
  logic                 brk_req;
  logic [1:0]           cond_flag;
  logic                 seq_armed;

  int checks;
  int fails;
  bit finished;

  dbgbrk_top #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_kind(bus_kind),
    .bus_addr(bus_addr), .bus_data(bus_data), .ch_en(ch_en), .ch_sel(ch_sel),
    .ch_post(ch_post), .ch_addr(ch_addr), .ch_mask(ch_mask), .ch_data(ch_data),
    .ch_data_en(ch_data_en), .seq_en(seq_en), .seq_clr(seq_clr),
    .flag_clr(flag_clr), .insn_done(insn_done), .done_trap(done_trap),
    .nx_exc(nx_exc), .nx_sleep(nx_sleep), .nx_nmi(nx_nmi),
    .brk_req(brk_req), .cond_flag(cond_flag), .seq_armed(seq_armed)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one bus cycle; returns shortly after the falling edge where inputs changed
  task automatic drive(input logic [1:0] k, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [4:0] side,
                       input logic [1:0] fclr, input logic sclr);
    @(negedge clk);
    bus_valid = (k != 2'd3);
    bus_kind  = k;
    bus_addr  = a;
    bus_data  = d;
    {insn_done, done_trap, nx_exc, nx_sleep, nx_nmi} = side;
    flag_clr  = fclr;
    seq_clr   = sclr;
    #1;
  endtask

  task automatic idle();
    drive(2'd3, '0, '0, S_NONE, 2'b00, 1'b0);
  endtask

  task automatic flush();
    drive(2'd3, '0, '0, S_DONE, 2'b11, 1'b1);
    idle();
  endtask

  task automatic set_chan(input int c, input logic [1:0] sel, input logic post,
                          input logic [AW-1:0] a, input logic [AW-1:0] m,
                          input logic [DW-1:0] d, input logic den);
    ch_en[c]      = 1'b1;
    ch_sel[c]     = sel;
    ch_post[c]    = post;
    ch_addr[c]    = a;
    ch_mask[c]    = m;
    ch_data[c]    = d;
    ch_data_en[c] = den;
  endtask

  task automatic t_reset();
    chk("R6", "flags after reset", 32'(cond_flag), 0);
    chk("R7", "armed after reset", 32'(seq_armed), 0);
    chk("R3", "brk after reset", 32'(brk_req), 0);
  endtask

  task automatic t_mask_pre();
    ch_en = 2'b00; seq_en = 1'b0;
    set_chan(0, 2'd0, 1'b0, 32'h1000, 32'h0000_000F, '0, 1'b0);
    drive(2'd0, 32'h1008, '0, S_NONE, 2'b00, 1'b0);
    chk("R3", "pre fetch masked hit", 32'(brk_req), 1);
    drive(2'd0, 32'h1010, '0, S_NONE, 2'b00, 1'b0);
    chk("R1", "unmasked bit differs", 32'(brk_req), 0);
    drive(2'd1, 32'h1008, '0, S_NONE, 2'b00, 1'b0);
    chk("R1", "read vs fetch select", 32'(brk_req), 0);
    chk("R6", "flag A set by hit", 32'(cond_flag[0]), 1);
    drive(2'd0, 32'h1004, '0, S_NONE, 2'b01, 1'b0);
    idle();
    chk("R6", "set wins over clear", 32'(cond_flag[0]), 1);
    drive(2'd3, '0, '0, S_NONE, 2'b01, 1'b0);
    idle();
    chk("R6", "flag A cleared", 32'(cond_flag[0]), 0);
    flush();
  endtask

  task automatic t_data();
    ch_en = 2'b00; seq_en = 1'b0;
    set_chan(1, 2'd1, 1'b0, 32'h2000, '0, 32'hAA, 1'b1);
    drive(2'd1, 32'h2000, 32'hAB, S_NONE, 2'b00, 1'b0);
    drive(2'd3, '0, '0, S_DONE, 2'b00, 1'b0);
    chk("R2", "data mismatch no break", 32'(brk_req), 0);
    chk("R2", "data mismatch no flag", 32'(cond_flag[1]), 0);
    drive(2'd1, 32'h2000, 32'hAA, S_NONE, 2'b00, 1'b0);
    chk("R2", "data hit waits for done", 32'(brk_req), 0);
    drive(2'd3, '0, '0, S_DONE, 2'b00, 1'b0);
    chk("R2", "data break on done", 32'(brk_req), 1);
    chk("R2", "flag B on data hit", 32'(cond_flag[1]), 1);
    flush();
  endtask

  task automatic t_post();
    ch_en = 2'b00; seq_en = 1'b0;
    set_chan(0, 2'd0, 1'b1, 32'h3000, '0, '0, 1'b0);
    drive(2'd0, 32'h3000, '0, S_NONE, 2'b00, 1'b0);
    chk("R4", "post not in fetch cycle", 32'(brk_req), 0);
    idle();
    chk("R4", "post waits", 32'(brk_req), 0);
    drive(2'd3, '0, '0, S_DONE, 2'b00, 1'b0);
    chk("R4", "post on done", 32'(brk_req), 1);
    drive(2'd3, '0, '0, S_DONE, 2'b00, 1'b0);
    chk("R4", "pending consumed", 32'(brk_req), 0);
    flush();
  endtask

  task automatic t_priority();
    ch_en = 2'b00; seq_en = 1'b0;
    set_chan(0, 2'd0, 1'b0, 32'h4000, '0, '0, 1'b0);
    set_chan(1, 2'd0, 1'b1, 32'h4000, '0, '0, 1'b0);
    drive(2'd0, 32'h4000, '0, S_NONE, 2'b00, 1'b0);
    chk("R5", "pre request issued", 32'(brk_req), 1);
    idle();
    chk("R5", "both flags set", 32'(cond_flag), 3);
    drive(2'd3, '0, '0, S_DONE, 2'b00, 1'b0);
    chk("R5", "no late post request", 32'(brk_req), 0);
    flush();
  endtask

  task automatic t_trap_nmi();
    ch_en = 2'b00; seq_en = 1'b0;
    set_chan(0, 2'd0, 1'b1, 32'h3100, '0, '0, 1'b0);
    drive(2'd0, 32'h3100, '0, S_NONE, 2'b00, 1'b0);
    drive(2'd3, '0, '0, S_TRAP, 2'b00, 1'b0);
    chk("R10", "trap drops post break", 32'(brk_req), 0);
    chk("R10", "trap keeps flag", 32'(cond_flag[0]), 1);
    drive(2'd3, '0, '0, S_DONE, 2'b00, 1'b0);
    chk("R10", "dropped break not replayed", 32'(brk_req), 0);
    flush();
    drive(2'd0, 32'h3100, '0, S_NONE, 2'b00, 1'b0);
    drive(2'd3, '0, '0, S_NMI, 2'b00, 1'b0);
    chk("R12", "nmi drops post break", 32'(brk_req), 0);
    chk("R12", "nmi keeps flag", 32'(cond_flag[0]), 1);
    flush();
  endtask

  task automatic t_data_suppress();
    ch_en = 2'b00; seq_en = 1'b0;
    set_chan(1, 2'd2, 1'b0, 32'h2200, '0, 32'h55, 1'b1);
    drive(2'd2, 32'h2200, 32'h55, S_NONE, 2'b00, 1'b0);
    drive(2'd3, '0, '0, S_EXC, 2'b00, 1'b0);
    chk("R11", "exception drops data break", 32'(brk_req), 0);
    chk("R11", "exception keeps flag", 32'(cond_flag[1]), 1);
    flush();
    drive(2'd2, 32'h2200, 32'h55, S_NONE, 2'b00, 1'b0);
    drive(2'd3, '0, '0, S_SLEEP, 2'b00, 1'b0);
    chk("R11", "sleep drops data break", 32'(brk_req), 0);
    chk("R11", "sleep keeps flag", 32'(cond_flag[1]), 1);
    flush();
  endtask

  task automatic t_seq_basic();
    ch_en = 2'b00; seq_en = 1'b1;
    set_chan(0, 2'd0, 1'b0, 32'h5000, '0, '0, 1'b0);
    set_chan(1, 2'd0, 1'b0, 32'h6000, '0, '0, 1'b0);
    drive(2'd0, 32'h5000, '0, S_NONE, 2'b00, 1'b0);
    chk("R7", "A alone no break", 32'(brk_req), 0);
    idle();
    chk("R7", "armed after A", 32'(seq_armed), 1);
    chk("R7", "flags after A", 32'(cond_flag), 1);
    drive(2'd0, 32'h6000, '0, S_NONE, 2'b00, 1'b0);
    chk("R7", "B completes with break", 32'(brk_req), 1);
    idle();
    chk("R7", "flag B after completion", 32'(cond_flag[1]), 1);
    chk("R7", "disarmed after completion", 32'(seq_armed), 0);
    flush();
  endtask

  task automatic t_seq_same();
    ch_en = 2'b00; seq_en = 1'b1;
    set_chan(0, 2'd1, 1'b0, 32'h7000, '0, '0, 1'b0);
    set_chan(1, 2'd1, 1'b0, 32'h7000, '0, '0, 1'b0);
    drive(2'd1, 32'h7000, '0, S_NONE, 2'b00, 1'b0);
    drive(2'd3, '0, '0, S_DONE, 2'b00, 1'b0);
    chk("R8", "same-cycle A and B no break", 32'(brk_req), 0);
    chk("R8", "same-cycle flag B clear", 32'(cond_flag[1]), 0);
    chk("R8", "same-cycle still armed", 32'(seq_armed), 1);
    flush();
  endtask

  task automatic t_seq_order();
    ch_en = 2'b00; seq_en = 1'b1;
    set_chan(0, 2'd2, 1'b0, 32'h8000, '0, '0, 1'b0);
    set_chan(1, 2'd0, 1'b0, 32'h8100, '0, '0, 1'b0);
    drive(2'd0, 32'h8100, '0, S_NONE, 2'b00, 1'b0);
    chk("R9", "B before A no break", 32'(brk_req), 0);
    drive(2'd2, 32'h8000, 32'h1, S_NONE, 2'b00, 1'b0);
    chk("R9", "A write no break", 32'(brk_req), 0);
    drive(2'd0, 32'h8100, '0, S_NONE, 2'b00, 1'b0);
    chk("R9", "B fetch after A write", 32'(brk_req), 1);
    flush();
  endtask

  task automatic t_seq_clear();
    ch_en = 2'b00; seq_en = 1'b1;
    set_chan(0, 2'd0, 1'b0, 32'h9000, '0, '0, 1'b0);
    set_chan(1, 2'd0, 1'b0, 32'h9100, '0, '0, 1'b0);
    drive(2'd0, 32'h9000, '0, S_NONE, 2'b00, 1'b0);
    drive(2'd0, 32'h9000, '0, S_NONE, 2'b00, 1'b1);
    idle();
    chk("R13", "clear beats A hit", 32'(seq_armed), 0);
    drive(2'd0, 32'h9100, '0, S_NONE, 2'b00, 1'b0);
    chk("R13", "B after clear no break", 32'(brk_req), 0);
    flush();
  endtask

  initial begin
    checks = 0; fails = 0; finished = 0;
    rst_n = 1'b0;
    bus_valid = 1'b0; bus_kind = 2'd3; bus_addr = '0; bus_data = '0;
    ch_en = '0; ch_sel = '0; ch_post = '0; ch_addr = '0; ch_mask = '0;
    ch_data = '0; ch_data_en = '0; seq_en = 1'b0; seq_clr = 1'b0;
    flag_clr = '0; insn_done = 1'b0; done_trap = 1'b0; nx_exc = 1'b0;
    nx_sleep = 1'b0; nx_nmi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_mask_pre();
    t_data();
    t_post();
    t_priority();
    t_trap_nmi();
    t_data_suppress();
    t_seq_basic();
    t_seq_same();
    t_seq_order();
    t_seq_clear();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule